// File: doc/BRIEF.md
# 64-bit SECDED Check-Byte Codec

This block protects a 64-bit word with an 8-bit check byte built from a fixed parity-check matrix. Each check bit is the even parity of a masked selection of the word: a 32-bit mask is applied to the upper half and another to the lower half. Every one of the eight check bits has its own mask pair. When a word and the check byte stored with it come in, the block XORs the freshly computed check byte with the received one to form a syndrome. It then sorts the result into one of four outcomes: clean, one faulty data bit (with its position), one faulty check bit (with its position), or uncorrectable. It also returns the word with any correctable data-bit error flipped back.

The same datapath serves as an encoder. When the received check byte is held at zero, the syndrome output equals the check byte of the presented word. The interface has no handshake. A word presented with `inValid` high produces its result two clock edges later, marked by `outValid`, and a new word can be accepted on every cycle.

Top module: `ecc_secded_codec`

## Requirements
- R1: Check bit i (i = 0..7) is the XOR of all bits of (word[63:32] & HI[i]) and (word[31:0] & LO[i]), where bit j of each half lines up with bit j of its mask. The masks are HI = {f00fe11e, 00ff00ff, 0f0f0f0f, 11113333, 22224444, 44448888, 8888ffff, ffff1111} and LO = {c33c0ff7, 00fff0ff, 0f0fff00, 7777000f, 8888222f, ffff4441, 11118882, 22221114}, listed for i = 0 to 7.
- R2: `outSyndrome` equals the computed check byte of the received word XOR the received check byte. With a received check byte of zero it is the check byte of the word.
- R3: A zero syndrome gives `outKind` = 0 (clean), `outIndex` = 0, and `outData` equal to the received word.
- R4: The column of data bit b is an 8-bit value whose bit i is LO[i][b] for b < 32 and HI[i][b-32] otherwise. If the syndrome equals any column, `outKind` = 1 (data error), `outIndex` = the lowest b whose column matches, and `outData` = the received word with bit b inverted. This test takes priority over R5.
- R5: A syndrome that matches no column and has exactly one bit set gives `outKind` = 2 (check-bit error), `outIndex` = the position of that bit, and the received word unchanged.
- R6: A nonzero syndrome that matches no column and has two or more bits set gives `outKind` = 3 (uncorrectable), `outIndex` = 0, and the received word unchanged.
- R7: A word sampled at a rising edge with `inValid` high appears on the outputs after the second following rising edge, with `outValid` high for exactly that cycle. Words presented on consecutive cycles come out on consecutive cycles in the same order.
- R8: While no new result arrives, `outKind`, `outIndex`, `outData` and `outSyndrome` keep their previous values and `outValid` is low.
- R9: An active-low `rstN` forces `outValid` low, both during reset and afterwards until a word presented after reset has passed through. A word still in flight when reset is asserted is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Marks a word to be decoded this cycle |
| inData | input | 64 | Received data word |
| inCheck | input | 8 | Received check byte (zero to encode) |
| outValid | output | 1 | Result below is new this cycle |
| outKind | output | 2 | 0 clean, 1 data-bit error, 2 check-bit error, 3 uncorrectable |
| outIndex | output | 6 | Faulty bit position for kinds 1 and 2, else 0 |
| outData | output | 64 | Received word with any correctable data error repaired |
| outSyndrome | output | 8 | Computed check byte XOR received check byte |

## Verification
The embedded properties check the following on every cycle:
- the two-edge valid latency and the absence of spurious `outValid` pulses;
- a clean outcome only with a zero syndrome;
- a check-bit outcome only with a one-hot syndrome whose set bit is the reported index;
- an uncorrectable outcome only with a multi-bit syndrome;
- a repaired word that differs from the received word in exactly one bit;
- held outputs when no result is loaded.

What the properties cannot show is whether the mask constants, the column search order and the chosen index are right. The bench covers these with its independent column-accumulating model. It runs a sweep over all 64 single data-bit faults and all 8 check-bit faults, plus multi-bit patterns searched for at run time, so that uncorrectable and pure check-bit outcomes are certain to occur.

// File: rtl/ecc_codec_pkg.sv
`timescale 1ns/1ps
package ecc_codec_pkg;

  localparam int DATA_W  = 64;
  localparam int HALF_W  = DATA_W / 2;
  localparam int CHECK_W = 8;
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int KIND_W  = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_NONE   = 2'd0,
    KIND_DATA   = 2'd1,
    KIND_CHECK  = 2'd2,
    KIND_UNCORR = 2'd3
  } ecc_kind_t;

  typedef struct packed {
    logic loadSyn;
    logic loadRes;
  } ecc_strobes_t;

  localparam logic [HALF_W-1:0] MASK_HI [CHECK_W] = '{
    32'hf00fe11e, 32'h00ff00ff, 32'h0f0f0f0f, 32'h11113333,
    32'h22224444, 32'h44448888, 32'h8888ffff, 32'hffff1111
  };
  localparam logic [HALF_W-1:0] MASK_LO [CHECK_W] = '{
    32'hc33c0ff7, 32'h00fff0ff, 32'h0f0fff00, 32'h7777000f,
    32'h8888222f, 32'hffff4441, 32'h11118882, 32'h22221114
  };

  // Row-wise parity of the masked halves.
  function automatic logic [CHECK_W-1:0] calcCheck(input logic [DATA_W-1:0] word);
    logic [CHECK_W-1:0] chk;
    for (int i = 0; i < CHECK_W; i++)
      chk[i] = ^((word[DATA_W-1:HALF_W] & MASK_HI[i]) ^ (word[HALF_W-1:0] & MASK_LO[i]));
    return chk;
  endfunction

  // Syndrome produced by a single flipped data bit at position pos.
  function automatic logic [CHECK_W-1:0] columnOf(input int pos);
    logic [CHECK_W-1:0] col;
    logic [4:0]         sub;
    sub = pos[4:0];
    for (int i = 0; i < CHECK_W; i++)
      col[i] = (pos < HALF_W) ? MASK_LO[i][sub] : MASK_HI[i][sub];
    return col;
  endfunction

endpackage

// File: rtl/ecc_codec_ctrl.sv
`timescale 1ns/1ps
module ecc_codec_ctrl
  import ecc_codec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output ecc_strobes_t strobes,
  output logic         resValid
);

  logic stage1Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      resValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      resValid    <= stage1Valid;
    end
  end

  always_comb begin
    strobes.loadSyn = inValid;
    strobes.loadRes = stage1Valid;
  end

  // R7: an accepted word yields a valid result two edges later.
  assert_two_edge_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 resValid);

  // R7: no result without a word two edges earlier.
  assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !stage1Valid) |=> ##1 !resValid);

endmodule

// File: rtl/ecc_codec_datapath.sv
`timescale 1ns/1ps
module ecc_codec_datapath
  import ecc_codec_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ecc_strobes_t       strobes,
  input  logic               resValid,
  input  logic [DATA_W-1:0]  inData,
  input  logic [CHECK_W-1:0] inCheck,
  output ecc_kind_t          resKind,
  output logic [IDX_W-1:0]   resIndex,
  output logic [DATA_W-1:0]  resData,
  output logic [CHECK_W-1:0] resSyn
);

  // Stage 1: syndrome register.
  logic [DATA_W-1:0]  synData;
  logic [CHECK_W-1:0] synReg;

  always_ff @(posedge clk) begin
    if (strobes.loadSyn) begin
      synData <= inData;
      synReg  <= calcCheck(inData) ^ inCheck;
    end
  end

  // Stage 2: classification.
  logic               colHit;
  logic [IDX_W-1:0]   colIdx;
  logic [IDX_W-1:0]   chkIdx;
  logic               synOneHot;
  ecc_kind_t          nextKind;
  logic [IDX_W-1:0]   nextIndex;
  logic [DATA_W-1:0]  nextData;

  // Descending scan so the lowest matching column wins.
  always_comb begin
    colHit = 1'b0;
    colIdx = '0;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      if (synReg == columnOf(b)) begin
        colHit = 1'b1;
        colIdx = IDX_W'(b);
      end
    end
  end

  always_comb begin
    chkIdx = '0;
    for (int k = CHECK_W - 1; k >= 0; k--)
      if (synReg[k]) chkIdx = IDX_W'(k);
  end

  assign synOneHot = $onehot(synReg);

  always_comb begin
    nextKind  = KIND_UNCORR;
    nextIndex = '0;
    nextData  = synData;
    if (synReg == '0) begin
      nextKind = KIND_NONE;
    end else if (colHit) begin
      nextKind  = KIND_DATA;
      nextIndex = colIdx;
      nextData  = synData ^ (DATA_W'(1) << colIdx);
    end else if (synOneHot) begin
      nextKind  = KIND_CHECK;
      nextIndex = chkIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.loadRes) begin
      resKind  <= nextKind;
      resIndex <= nextIndex;
      resData  <= nextData;
      resSyn   <= synReg;
    end
  end

  // R3: a clean outcome only with a zero syndrome.
  assert_clean_zero_syn_R3: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resKind == KIND_NONE) |-> (resSyn == '0));

  // R4: a repaired word differs from the received one in exactly one bit.
  assert_single_flip_fix_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRes |=> (resKind != KIND_DATA) || ($countones(resData ^ $past(synData)) == 1));

  // R5: a check-bit outcome carries a one-hot syndrome at the reported position.
  assert_check_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resKind == KIND_CHECK) |-> ($onehot(resSyn) && resSyn[resIndex[2:0]]));

  // R6: uncorrectable only for multi-bit syndromes.
  assert_uncorr_multibit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resKind == KIND_UNCORR) |-> ($countones(resSyn) > 1));

  // R8: results hold while nothing is loaded.
  assert_hold_results_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadRes |=> ($stable(resData) && $stable(resKind) && $stable(resIndex) && $stable(resSyn)));

endmodule

// File: rtl/ecc_secded_codec.sv
`timescale 1ns/1ps
module ecc_secded_codec
  import ecc_codec_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  inData,
  input  logic [CHECK_W-1:0] inCheck,
  output logic               outValid,
  output logic [KIND_W-1:0]  outKind,
  output logic [IDX_W-1:0]   outIndex,
  output logic [DATA_W-1:0]  outData,
  output logic [CHECK_W-1:0] outSyndrome
);

  ecc_strobes_t strobes;
  ecc_kind_t    resKind;

  ecc_codec_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .resValid (outValid)
  );

  ecc_codec_datapath i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .resValid (outValid),
    .inData   (inData),
    .inCheck  (inCheck),
    .resKind  (resKind),
    .resIndex (outIndex),
    .resData  (outData),
    .resSyn   (outSyndrome)
  );

  assign outKind = resKind;

endmodule

// File: tb/test_ecc_secded_codec.sv
`timescale 1ns/1ps
module test_ecc_secded_codec;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] inData = '0;
  logic [7:0]  inCheck = '0;
  logic        outValid;
  logic [1:0]  outKind;
  logic [5:0]  outIndex;
  logic [63:0] outData;
  logic [7:0]  outSyndrome;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ecc_secded_codec i_ecc_secded_codec (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inCheck(inCheck),
    .outValid(outValid), .outKind(outKind), .outIndex(outIndex),
    .outData(outData), .outSyndrome(outSyndrome)
  );

  // Spec constants, row i = check bit i.
  localparam logic [31:0] SPEC_HI [8] = '{
    32'hf00fe11e, 32'h00ff00ff, 32'h0f0f0f0f, 32'h11113333,
    32'h22224444, 32'h44448888, 32'h8888ffff, 32'hffff1111
  };
  localparam logic [31:0] SPEC_LO [8] = '{
    32'hc33c0ff7, 32'h00fff0ff, 32'h0f0fff00, 32'h7777000f,
    32'h8888222f, 32'hffff4441, 32'h11118882, 32'h22221114
  };

  // Stimulus rows: {base word, data flip mask, check flip mask}.
  localparam logic [135:0] VECS [12] = '{
    {64'h0000000000000000, 64'h0000000000000000, 8'h00},
    {64'hffffffffffffffff, 64'h0000000000000000, 8'h00},
    {64'h0123456789abcdef, 64'h0000000000000001, 8'h00},
    {64'h0123456789abcdef, 64'h8000000000000000, 8'h00},
    {64'ha5a5a5a5a5a5a5a5, 64'h0000000100000000, 8'h00},
    {64'hdeadbeefcafef00d, 64'h0000000000000000, 8'h01},
    {64'hdeadbeefcafef00d, 64'h0000000000000000, 8'h80},
    {64'h5555aaaa5555aaaa, 64'h0000000000000003, 8'h00},
    {64'hfedcba9876543210, 64'h0000000080000000, 8'h00},
    {64'h0f0f0f0f0f0f0f0f, 64'h0000000000000001, 8'h01},
    {64'h1122334455667788, 64'h0000000000000000, 8'h03},
    {64'hcafebabecafebabe, 64'h8000000000000001, 8'h00}
  };

  function automatic logic [7:0] refColumn(input int pos);
    logic [7:0] c;
    for (int i = 0; i < 8; i++)
      c[i] = (pos >= 32) ? SPEC_HI[i][pos-32] : SPEC_LO[i][pos];
    return c;
  endfunction

  // Column accumulation: every set data bit contributes its column.
  function automatic logic [7:0] refCheck(input logic [63:0] w);
    logic [7:0] acc = '0;
    for (int j = 0; j < 64; j++)
      if (w[j]) acc ^= refColumn(j);
    return acc;
  endfunction

  function automatic int firstColumn(input logic [7:0] s);
    for (int j = 0; j < 64; j++)
      if (refColumn(j) == s) return j;
    return -1;
  endfunction

  task automatic refDecode(input logic [63:0] w, input logic [7:0] c,
                           output logic [1:0] kind, output logic [5:0] idx,
                           output logic [63:0] fixed, output logic [7:0] syn);
    int hit;
    syn = refCheck(w) ^ c;
    fixed = w;
    idx = '0;
    hit = firstColumn(syn);
    if (syn == 8'h00) kind = 2'd0;
    else if (hit >= 0) begin
      kind = 2'd1; idx = 6'(hit); fixed = w ^ (64'd1 << hit);
    end else if ($countones(syn) == 1) begin
      kind = 2'd2;
      for (int k = 7; k >= 0; k--) if (syn[k]) idx = 6'(k);
    end else kind = 2'd3;
  endtask

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one word, sample its result after two edges.
  task automatic runWord(input string req, input logic [63:0] w, input logic [7:0] c);
    logic [1:0] eKind; logic [5:0] eIdx; logic [63:0] eData; logic [7:0] eSyn;
    refDecode(w, c, eKind, eIdx, eData, eSyn);
    @(negedge clk); inValid = 1'b1; inData = w; inCheck = c;
    @(negedge clk); inValid = 1'b0;
    @(negedge clk);
    check(req, "valid", 64'(outValid), 64'd1);
    check(req, "kind", 64'(outKind), 64'(eKind));
    check(req, "index", 64'(outIndex), 64'(eIdx));
    check(req, "data", outData, eData);
    check("R2", "syndrome", 64'(outSyndrome), 64'(eSyn));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      testsFailed++;
      $display("FAIL R7 watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [63:0] w;
    logic [7:0]  s;
    logic [1:0]  k0; logic [5:0] i0; logic [63:0] d0; logic [7:0] s0;
    logic [1:0]  k1; logic [5:0] i1; logic [63:0] d1; logic [7:0] s1;
    logic [1:0]  k2; logic [5:0] i2; logic [63:0] d2; logic [7:0] s2;
    logic [1:0]  hk; logic [5:0] hi; logic [63:0] hd; logic [7:0] hs;

    // R9: reset state.
    repeat (3) @(negedge clk);
    check("R9", "valid in reset", 64'(outValid), 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R9", "valid after reset", 64'(outValid), 64'd0);

    // Table walk (R3..R6 per model).
    for (int v = 0; v < 12; v++) begin
      w = VECS[v][135:72];
      runWord("R4", w ^ VECS[v][71:8], refCheck(w) ^ VECS[v][7:0]);
    end

    // R1: encode with zero received check byte.
    w = 64'h0123456789abcdef;
    runWord("R1", w, 8'h00);
    check("R1", "encoded byte", 64'(outSyndrome), 64'(refCheck(w)));

    // R3: clean word round trip.
    runWord("R3", w, refCheck(w));
    check("R3", "clean kind", 64'(outKind), 64'd0);
    check("R3", "clean data", outData, w);

    // R4: every single data-bit fault.
    w = 64'h3c5a96e1f0871e2d;
    for (int b = 0; b < 64; b++) begin
      runWord("R4", w ^ (64'd1 << b), refCheck(w));
      check("R4", "data kind", 64'(outKind), 64'd1);
    end

    // R5: every single check-bit fault, plus a guaranteed pure check-bit case.
    for (int k = 0; k < 8; k++) runWord("R5", w, refCheck(w) ^ (8'd1 << k));
    for (int k = 0; k < 8; k++) begin
      if (firstColumn(8'd1 << k) < 0) begin
        runWord("R5", w, refCheck(w) ^ (8'd1 << k));
        check("R5", "check kind", 64'(outKind), 64'd2);
        check("R5", "check index", 64'(outIndex), 64'(k));
        check("R5", "check data", outData, w);
        break;
      end
    end

    // R6: a multi-bit syndrome matching no column.
    for (int q = 3; q < 256; q++) begin
      s = 8'(q);
      if ($countones(s) > 1 && firstColumn(s) < 0) begin
        runWord("R6", w, refCheck(w) ^ s);
        check("R6", "uncorr kind", 64'(outKind), 64'd3);
        check("R6", "uncorr index", 64'(outIndex), 64'd0);
        check("R6", "uncorr data", outData, w);
        break;
      end
    end

    // R8: results hold while idle.
    hk = outKind; hi = outIndex; hd = outData; hs = outSyndrome;
    repeat (3) @(negedge clk);
    check("R8", "idle valid", 64'(outValid), 64'd0);
    check("R8", "held data", outData, hd);
    check("R8", "held kind", 64'(outKind), 64'(hk));
    check("R8", "held index", 64'(outIndex), 64'(hi));
    check("R8", "held syndrome", 64'(outSyndrome), 64'(hs));

    // R7: back-to-back words.
    refDecode(64'h1, refCheck(64'h1), k0, i0, d0, s0);
    refDecode(64'h2 ^ 64'h10, refCheck(64'h2), k1, i1, d1, s1);
    refDecode(64'h4, refCheck(64'h4) ^ 8'hff, k2, i2, d2, s2);
    @(negedge clk); inValid = 1'b1; inData = 64'h1; inCheck = refCheck(64'h1);
    @(negedge clk); inData = 64'h12; inCheck = refCheck(64'h2);
    check("R7", "not yet valid", 64'(outValid), 64'd0);
    @(negedge clk); inData = 64'h4; inCheck = refCheck(64'h4) ^ 8'hff;
    check("R7", "word0 valid", 64'(outValid), 64'd1);
    check("R7", "word0 data", outData, d0);
    @(negedge clk); inValid = 1'b0;
    check("R7", "word1 valid", 64'(outValid), 64'd1);
    check("R7", "word1 data", outData, d1);
    check("R7", "word1 kind", 64'(outKind), 64'(k1));
    @(negedge clk);
    check("R7", "word2 valid", 64'(outValid), 64'd1);
    check("R7", "word2 syndrome", 64'(outSyndrome), 64'(s2));
    check("R7", "word2 kind", 64'(outKind), 64'(k2));
    @(negedge clk);
    check("R7", "valid single pulse", 64'(outValid), 64'd0);

    // R9: reset discards a word in flight.
    @(negedge clk); inValid = 1'b1; inData = 64'h55; inCheck = 8'h00;
    @(negedge clk); inValid = 1'b0; rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R9", "flushed valid", 64'(outValid), 64'd0);
    @(negedge clk);
    check("R9", "flushed valid later", 64'(outValid), 64'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule